// File: doc/BRIEF.md
# Nonce Generator: Shift Register with Periodic Noise Injection

This block produces 16-bit nonces from a 16-cell shift register whose feedback taps are chosen at run time. Every clock cycle of a generation round shifts the register up by one cell. The bit that leaves the top cell is the output bit. The bit that enters the bottom cell is the XOR parity of the cells selected by the tap mask. On the first shift of each round, one bit from an external noise source is also XORed into that entering bit. The noise source therefore has to supply only one bit for every sixteen output bits, and it can run sixteen times slower than the output bit rate.

A single-cycle request starts a round. Sixteen cycles later, the sixteen output bits appear together as one word, and a strobe marks them. The first bit shifted out is the word's most significant bit. The register keeps its contents between rounds, so consecutive nonces are consecutive stretches of one bit stream. A seed load overwrites the register and cancels any round in progress. A zero seed is replaced by a fixed nonzero value, so the register can never be seeded into lock-up. If the noise source has no valid bit at an injection slot, a zero is injected and a sticky underrun flag is raised.

Top module: `nonce_lfsr_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `nonce_valid`, `underrun` and `nonce_out` are 0. The register starts from 16'hACE1.
- R2: Each shift moves the register up one cell. The output bit is the top cell (bit 15) before the shift. The new bit 0 is the XOR of all cells whose `tap_mask` bit is 1.
- R3: On the first shift of every round, the new bit 0 is additionally XORed with `trn_bit`. This is the only XOR with `trn_bit` in the round.
- R4: `trn_bit` is sampled only at the injection slot. Its value during the other fifteen shifts of a round has no effect on the nonce.
- R5: If `trn_valid` is low at the injection slot, a 0 is injected and `underrun` goes high. `underrun` then stays high until reset.
- R6: A seed load of 16'h0000 loads 16'hACE1 instead. Any other seed is loaded unchanged.
- R7: The first bit output in a round lands in `nonce_out[15]` and the last in `nonce_out[0]`. The next round continues from the register state left by the previous one.
- R8: A request sampled in an idle cycle makes `nonce_valid` high for exactly one cycle, 16 cycles after that edge. `nonce_out` changes only together with that strobe.
- R9: A request sampled while a round is running is ignored.
- R10: A seed load cancels a running round, so no strobe follows it. The next request starts a fresh round from the loaded seed, with injection on its first shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load `seed_value` into the register and cancel any round |
| seed_value | input | 16 | Seed word (zero is replaced by 16'hACE1) |
| tap_mask | input | 16 | Feedback tap selection, one bit per cell |
| trn_bit | input | 1 | True-random bit from the noise source |
| trn_valid | input | 1 | `trn_bit` is valid |
| req | input | 1 | Start a 16-shift round when idle |
| nonce_out | output | 16 | Last completed nonce, first output bit in bit 15 |
| nonce_valid | output | 1 | One-cycle strobe when `nonce_out` updates |
| underrun | output | 1 | Sticky: an injection slot found no valid noise bit |

## Verification
The hardest behaviour to reach is the single injection slot inside a round. The bench cannot see this slot, so it has to prove that `trn_bit` is consumed on the first shift and on no other. To do this, the stimulus holds the noise bit at one value across the injection edge and then inverts it for the rest of the round. Only a model that injects on exactly that edge predicts the resulting nonce. Requests during a running round, and seed loads that cancel one, are timed to land on known cycle counts after the starting request. Random taps, seeds and noise bits then cover the rest of the behaviour, with `trn_valid` sometimes dropped to trigger underrun.

// File: rtl/nonce_lfsr_pkg.sv
package nonce_lfsr_pkg;

    localparam int unsigned NW = 16;
    localparam int unsigned CW = $clog2(NW);
    localparam logic [NW-1:0] SEED_FALLBACK = 16'hACE1;

    typedef logic [NW-1:0] word_t;

    typedef struct packed {
        logic shift;
        logic inject;
        logic inj_bit;
    } step_t;

    typedef enum logic {
        PK_IDLE = 1'b0,
        PK_RUN  = 1'b1
    } pk_phase_e;

    function automatic logic tap_parity(input word_t cells, input word_t taps);
        return ^(cells & taps);
    endfunction

    function automatic word_t sanitize_seed(input word_t s);
        return (s == '0) ? SEED_FALLBACK : s;
    endfunction

endpackage

// File: rtl/lfsr_core.sv
module lfsr_core
    import nonce_lfsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t load_val,
    input  word_t taps,
    input  step_t step,
    output logic  out_bit
);
    word_t cells;
    logic  fb;

    always_comb begin
        fb = tap_parity(cells, taps) ^ (step.inject & step.inj_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= SEED_FALLBACK;
        end else if (load) begin
            cells <= sanitize_seed(load_val);
        end else if (step.shift) begin
            cells <= {cells[NW-2:0], fb};
        end
    end

    assign out_bit = cells[NW-1];
endmodule

// File: rtl/noise_inject.sv
module noise_inject
    import nonce_lfsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift,
    input  logic  slot,
    input  logic  trn_bit,
    input  logic  trn_valid,
    output step_t step,
    output logic  underrun
);
    logic starve;

    always_comb begin
        step.shift   = shift;
        step.inject  = shift & slot;
        step.inj_bit = trn_bit & trn_valid;
        starve       = shift & slot & ~trn_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            underrun <= 1'b0;
        end else if (starve) begin
            underrun <= 1'b1;
        end
    end
endmodule

// File: rtl/nonce_packer.sv
module nonce_packer
    import nonce_lfsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  logic  abort,
    input  logic  bit_in,
    output logic  shift,
    output logic  slot,
    output word_t nonce,
    output logic  valid
);
    pk_phase_e       phase;
    logic [CW-1:0]   cnt;
    word_t           gather;
    logic            last;

    always_comb begin
        shift = (phase == PK_RUN) && !abort;
        slot  = (cnt == '0);
        last  = (cnt == CW'(NW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PK_IDLE;
            cnt    <= '0;
            gather <= '0;
            nonce  <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (abort) begin
                phase <= PK_IDLE;
                cnt   <= '0;
            end else if (phase == PK_RUN) begin
                gather <= {gather[NW-2:0], bit_in};
                if (last) begin
                    nonce <= {gather[NW-2:0], bit_in};
                    valid <= 1'b1;
                    phase <= PK_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (req) begin
                phase <= PK_RUN;
                cnt   <= '0;
            end
        end
    end
endmodule

// File: rtl/nonce_lfsr_gen.sv
module nonce_lfsr_gen
    import nonce_lfsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seed_load,
    input  logic [15:0] seed_value,
    input  logic [15:0] tap_mask,
    input  logic        trn_bit,
    input  logic        trn_valid,
    input  logic        req,
    output logic [15:0] nonce_out,
    output logic        nonce_valid,
    output logic        underrun
);
    logic  shift;
    logic  slot;
    logic  out_bit;
    step_t step;

    nonce_packer u_pack (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .abort  (seed_load),
        .bit_in (out_bit),
        .shift  (shift),
        .slot   (slot),
        .nonce  (nonce_out),
        .valid  (nonce_valid)
    );

    noise_inject u_inj (
        .clk       (clk),
        .rst       (rst),
        .shift     (shift),
        .slot      (slot),
        .trn_bit   (trn_bit),
        .trn_valid (trn_valid),
        .step      (step),
        .underrun  (underrun)
    );

    lfsr_core u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (seed_load),
        .load_val (seed_value),
        .taps     (tap_mask),
        .step     (step),
        .out_bit  (out_bit)
    );
endmodule

// File: rtl/nonce_lfsr_chk.sv
module nonce_lfsr_chk (
    input logic        clk,
    input logic        rst,
    input logic        seed_load,
    input logic        trn_valid,
    input logic [15:0] nonce_out,
    input logic        nonce_valid,
    input logic        underrun
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        nonce_valid |=> !nonce_valid); // R8

    AST_NONCE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !nonce_valid |-> $stable(nonce_out)); // R8

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun); // R5

    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(!trn_valid)); // R5

    AST_LOAD_CANCELS: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !nonce_valid); // R10
endmodule

bind nonce_lfsr_gen nonce_lfsr_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .seed_load   (seed_load),
    .trn_valid   (trn_valid),
    .nonce_out   (nonce_out),
    .nonce_valid (nonce_valid),
    .underrun    (underrun)
);

// File: tb/test_nonce_lfsr_gen.sv
module test_nonce_lfsr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        seed_load;
    logic [15:0] seed_value;
    logic [15:0] tap_mask;
    logic        trn_bit;
    logic        trn_valid;
    logic        req;
    logic [15:0] nonce_out;
    logic        nonce_valid;
    logic        underrun;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_state;
    logic        m_under;
    logic [15:0] m_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    nonce_lfsr_gen i_nonce_lfsr_gen (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .tap_mask(tap_mask), .trn_bit(trn_bit), .trn_valid(trn_valid), .req(req),
        .nonce_out(nonce_out), .nonce_valid(nonce_valid), .underrun(underrun)
    );

    function automatic logic [15:0] m_step(input logic [15:0] s, input logic [15:0] t,
                                           input logic inj, input logic b);
        return {s[14:0], (^(s & t)) ^ (inj & b)};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_seed(input logic [15:0] v);
        @(negedge clk);
        seed_value = v;
        seed_load  = 1'b1;
        @(negedge clk);
        seed_load  = 1'b0;
        m_state = (v == 16'h0) ? 16'hACE1 : v;
    endtask

    task automatic run_nonce(input logic [15:0] taps, input logic tb, input logic tv,
                             input logic flip_mid, input logic extra_req);
        logic [15:0] word = '0;
        logic [15:0] s = m_state;
        for (int i = 0; i < 16; i++) begin
            word = {word[14:0], s[15]};
            s = m_step(s, taps, i == 0, tb & tv);
        end
        m_state = s;
        if (!tv) m_under = 1'b1;
        @(negedge clk);
        tap_mask = taps; trn_bit = tb; trn_valid = tv; req = 1'b1;
        for (int cyc = 1; cyc <= 17; cyc++) begin
            @(negedge clk);
            if (cyc == 1) req = 1'b0;
            if (cyc == 2 && flip_mid) trn_bit = ~tb;
            if (cyc == 5 && extra_req) req = 1'b1;
            if (cyc == 6) req = 1'b0;
            if (cyc < 17 && nonce_valid)
                check(1'b0, "R8 early strobe", 32'(cyc), 32'd17);
        end
        check(nonce_valid == 1'b1, "R8 strobe at 16 cycles", 32'(nonce_valid), 32'd1);
        check(nonce_out == word, flip_mid ? "R4 nonce with late trn change" :
              "R2 R3 R7 nonce value", 32'(nonce_out), 32'(word));
        @(negedge clk);
        check(nonce_valid == 1'b0, "R8 strobe one cycle", 32'(nonce_valid), 32'd0);
        check(nonce_out == word, "R8 nonce held", 32'(nonce_out), 32'(word));
        check(underrun == m_under, "R5 underrun flag", 32'(underrun), 32'(m_under));
        m_last = word;
        if (extra_req) begin
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (nonce_valid || nonce_out != word)
                    check(1'b0, "R9 busy request started a round", 32'(nonce_out), 32'(word));
            end
            check(1'b1, "R9 no extra round", 32'd0, 32'd0);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        rst = 1'b1; seed_load = 1'b0; seed_value = '0; tap_mask = 16'hB400;
        trn_bit = 1'b0; trn_valid = 1'b1; req = 1'b0;
        m_state = 16'hACE1; m_under = 1'b0; m_last = '0;
        repeat (3) @(negedge clk);
        check(nonce_valid == 0 && underrun == 0 && nonce_out == 0, "R1 reset outputs",
              {15'd0, nonce_valid, underrun, nonce_out}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(nonce_valid == 0 && underrun == 0 && nonce_out == 0, "R1 after reset",
              {15'd0, nonce_valid, underrun, nonce_out}, 32'd0);

        // R1 default state, R2/R3 injection of 0 and 1, R7 continuity
        run_nonce(16'hB400, 1'b0, 1'b1, 1'b0, 1'b0);
        run_nonce(16'hB400, 1'b1, 1'b1, 1'b0, 1'b0);
        run_nonce(16'h8016, 1'b1, 1'b1, 1'b0, 1'b0);
        // R4: trn flips after the injection slot
        run_nonce(16'hB400, 1'b1, 1'b1, 1'b1, 1'b0);
        run_nonce(16'h6001, 1'b0, 1'b1, 1'b1, 1'b0);
        // R6: zero seed and plain seed
        load_seed(16'h0000);
        run_nonce(16'hD008, 1'b0, 1'b1, 1'b0, 1'b0);
        load_seed(16'h0001);
        run_nonce(16'hD008, 1'b0, 1'b1, 1'b0, 1'b0);
        // R9: request during a running round
        run_nonce(16'hB400, 1'b1, 1'b1, 1'b0, 1'b1);
        // R10: seed load cancels a round
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (4) @(negedge clk);
        load_seed(16'h1234);
        for (int c = 0; c < 25; c++) begin
            @(negedge clk);
            if (nonce_valid || nonce_out != m_last)
                check(1'b0, "R10 cancelled round produced a strobe", 32'(nonce_out), 32'(m_last));
        end
        check(1'b1, "R10 no strobe after cancel", 32'd0, 32'd0);
        run_nonce(16'hB400, 1'b1, 1'b1, 1'b0, 1'b0);
        // R5: underrun then sticky
        run_nonce(16'hB400, 1'b1, 1'b0, 1'b0, 1'b0);
        run_nonce(16'hB400, 1'b1, 1'b1, 1'b0, 1'b0);
        // Random rounds
        for (int k = 0; k < 40; k++) begin
            if ($urandom_range(0, 5) == 0) load_seed(16'($urandom));
            run_nonce(16'($urandom), 1'($urandom), $urandom_range(0, 7) != 0,
                      1'($urandom), 1'b0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule